// File: doc/BRIEF.md
# Dual-Modulus 15/16 Prescaler

This block divides its input clock by 15 or by 16, with the ratio chosen by a single select input. It is built from two cascaded stages. A 2-bit twisted-ring (Johnson) counter runs at the input rate and normally walks four states. A 2-bit quarter counter advances once each time the ring counter wraps. In the last quarter-counter state, and only when the select is low, the ring counter skips one state. That period is then 15 input clocks long instead of 16.

The select input is captured once per output period, on the clock edge that moves the quarter counter into its last state. A fractional-N loop can therefore change the ratio on every output period, and the synthesizer gets its fractional average from that pattern. The block provides two outputs. One is a divided clock, taken from the top bit of the quarter counter. The other is a terminal pulse that is high during the final input cycle of each period. The quarter counter's width is a parameter, so a wider second stage gives a ratio pair of 4·2^W − 1 and 4·2^W.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While `rst_n` is low, both stages are held at state zero, so `div_out` and `term_pulse` both read 0.
- R2: With `mod_sel` held at 1, there are exactly 16 input clocks from one `term_pulse` to the next.
- R3: With `mod_sel` held at 0, there are exactly 15 input clocks from one `term_pulse` to the next.
- R4: Within each period, `div_out` is low for the first 8 input cycles and high for the rest. It is high for 8 cycles in a 16-cycle period and for 7 cycles in a 15-cycle period, because the shortened ring cycle falls only in the last quarter-counter state.
- R5: `term_pulse` is high for exactly one input cycle, the last cycle of each period, and is low in the first cycle of the next period.
- R6: The ratio of a period is set by the value of `mod_sel` at the rising edge that ends input cycle 12 of that period. A change made during cycle 12 or earlier takes effect in the same period. A change made in cycle 13 or later does not alter that period.
- R7: Driving `mod_sel` with 1 and 0 on alternate periods gives 31 input clocks per pair of periods.
- R8: The first period after `rst_n` is released already has the length selected by `mod_sel`: 15 for 0 and 16 for 1. Cycle 1 is the cycle in which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_sel | input | 1 | Ratio select: 1 divides by 16, 0 divides by 15 |
| div_out | output | 1 | Divided clock, the top bit of the quarter counter |
| term_pulse | output | 1 | One-cycle pulse in the last input cycle of each period |

## Verification
`term_pulse` and `div_out` are decoded straight from the stage registers. Each one therefore reflects the state entered on the preceding rising edge. The bench samples both outputs on every falling edge and numbers those samples from 1 within a period. The sample that shows `term_pulse` high is the period's last cycle and gives its length.

The select is captured on the rising edge that ends cycle 12. For that reason the bench moves `mod_sel` on the falling edge of a chosen cycle, either 12 or 13, and the outcome appears in the length of that same period. After a reset, the bench releases `rst_n` just past a rising edge, so that the next falling-edge sample is counted as cycle 1.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  typedef logic [1:0] ring_t;

  localparam ring_t RING_A = 2'b00;
  localparam ring_t RING_B = 2'b01;
  localparam ring_t RING_C = 2'b11;
  localparam ring_t RING_D = 2'b10;

  // Next twisted-ring state: the low bit takes the inverted high bit, the
  // high bit takes the low bit, except that from RING_C with long_mode low
  // the counter returns straight to RING_A (three-state cycle).
  function automatic ring_t ring_next(input ring_t cur, input logic long_mode);
    ring_t nx;
    nx[1] = cur[0] & (long_mode | ~cur[1]);
    nx[0] = ~cur[1];
    return nx;
  endfunction

  // Input clocks per output period for a quarter counter of width w.
  function automatic int period_len(input logic long_sel, input int w);
    return 4 * (2 ** w) - (long_sel ? 0 : 1);
  endfunction

endpackage

// File: rtl/ring_stage.sv
module ring_stage
  import dmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic long_mode,
  output logic wrap
);

  ring_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= RING_A;
    else        st <= ring_next(st, long_mode);
  end

  assign wrap = (st == RING_D) | ((st == RING_C) & ~long_mode);

  // R4: short and long exits from the third ring state
  a_r4_ring_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RING_C && !long_mode) |=> (st == RING_A));
  a_r4_ring_long: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RING_C && long_mode) |=> (st == RING_D));
  a_r4_ring_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RING_A) |=> (st == RING_B));

endmodule

// File: rtl/quarter_stage.sv
module quarter_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         at_last
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + ONE;
  end

  assign at_last = &cnt;

  // R4: the second stage moves only when the ring stage wraps
  a_r4_quarter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  a_r4_quarter_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/mod_gate.sv
module mod_gate #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_sel,
  input  logic         step,
  input  logic [W-1:0] cnt,
  input  logic         at_last,
  output logic         long_mode
);

  localparam logic [W-1:0] PRE_SLOT = W'((2 ** W) - 2);

  logic sel_held;
  logic load;

  assign load = step & (cnt == PRE_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_held <= 1'b0;
    else if (load) sel_held <= mod_sel;
  end

  assign long_mode = sel_held | ~at_last;

  // R6: the select is captured only when entering the slot state
  a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_held));
  a_r6_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sel_held == $past(mod_sel)));

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int SEC_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_sel,
  output logic div_out,
  output logic term_pulse
);

  localparam int LEN_SHORT = period_len(1'b0, SEC_W);
  localparam int LEN_LONG  = period_len(1'b1, SEC_W);
  localparam int CW        = $clog2(LEN_LONG + 1);

  logic             long_mode;
  logic             ring_wrap;
  logic [SEC_W-1:0] qcnt;
  logic             q_last;

  ring_stage u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_mode (long_mode),
    .wrap      (ring_wrap)
  );

  quarter_stage #(.W(SEC_W)) u_quarter (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (ring_wrap),
    .cnt     (qcnt),
    .at_last (q_last)
  );

  mod_gate #(.W(SEC_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_sel   (mod_sel),
    .step      (ring_wrap),
    .cnt       (qcnt),
    .at_last   (q_last),
    .long_mode (long_mode)
  );

  assign div_out    = qcnt[SEC_W-1];
  assign term_pulse = ring_wrap & q_last;

  // Checker state: input clocks since the last terminal pulse
  logic [CW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_cnt <= '0;
    else if (term_pulse) chk_cnt <= '0;
    else                 chk_cnt <= chk_cnt + CW'(1);
  end

  // R2 / R3: every period is one of the two legal lengths
  a_r3_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> ((chk_cnt == CW'(LEN_SHORT - 1)) || (chk_cnt == CW'(LEN_LONG - 1))));
  // R5: the terminal pulse never lasts two cycles
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse);
  // R1: outputs idle under reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!div_out && !term_pulse);
    end
  end

endmodule

// File: tb/test_dual_mod_prescaler.sv
module test_dual_mod_prescaler;

  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // columns: start select, change cycle (0 = none), new select, length, high cycles
  localparam int VEC [NV][5] = '{
    '{1, 0,  0, 16, 8},
    '{0, 0,  0, 15, 7},
    '{1, 0,  0, 16, 8},
    '{0, 0,  0, 15, 7},
    '{0, 12, 1, 16, 8},
    '{0, 13, 1, 15, 7},
    '{1, 13, 0, 16, 8},
    '{1, 12, 0, 15, 7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_sel = 1'b0;
  logic div_out;
  logic term_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  dual_mod_prescaler i_dual_mod_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_sel    (mod_sel),
    .div_out    (div_out),
    .term_pulse (term_pulse)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling-edge samples up to and including the one with term_pulse.
  task automatic measure(input int chg_at, input logic chg_val,
                         output int len, output int hi, output int pulse_first);
    bit done;
    len = 0; hi = 0; pulse_first = 0; done = 0;
    while (!done) begin
      @(negedge clk); #1;
      len++;
      if (div_out) hi++;
      if (len == 1) pulse_first = int'(term_pulse);
      if (len == chg_at) mod_sel = chg_val;
      if (term_pulse || len > 40) done = 1;
    end
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0;
    mod_sel = sel;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 div_out in reset", int'(div_out), 0);
    chk("R1 term_pulse in reset", int'(term_pulse), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    int len, hi, pf, pair;
    do_reset(1'b1);
    measure(0, 1'b0, len, hi, pf);
    chk("R8 first period long", len, 16);

    // table-driven periods: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      mod_sel = VEC[v][0][0];
      measure(VEC[v][1], VEC[v][2][0], len, hi, pf);
      chk($sformatf("R2/R3/R6 length row %0d", v), len, VEC[v][3]);
      chk($sformatf("R4 div_out high row %0d", v), hi, VEC[v][4]);
      chk($sformatf("R5 no pulse at cycle 1 row %0d", v), pf, 0);
    end

    // R7: alternating select
    for (int p = 0; p < 4; p++) begin
      mod_sel = 1'b1;
      measure(0, 1'b0, len, hi, pf);
      pair = len;
      mod_sel = 1'b0;
      measure(0, 1'b0, len, hi, pf);
      pair += len;
      chk($sformatf("R7 pair %0d length", p), pair, 31);
    end

    // R8 / R1: reset mid-run then short first period
    do_reset(1'b0);
    measure(0, 1'b0, len, hi, pf);
    chk("R8 first period short", len, 15);
    chk("R4 first period high", hi, 7);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule